// File: doc/BRIEF.md
# Legacy Sound DSP Command Responder

This block stands in for the byte-wide command interface of an old game sound card's signal processor. Host software writes opcodes and parameter bytes, polls two status bytes, reads reply bytes and toggles a reset port, exactly as it did on the original card. The block parses each opcode along with its parameters, queues replies, passes direct-mode samples and 8-bit single-cycle playback setups on to downstream logic, and raises an interrupt flag. Only playback moves audio. Recording opcodes still take their parameters and give a plausible answer, so polling drivers never stall.

Host port accesses are single-cycle strobes (`hw_en`, `hr_en`) with a port select. Two outputs are valid/ready streams: the direct sample (`smp_*`) and the playback request (`dma_*`). A stream holds valid and its payload stable until the consumer asserts ready in the same cycle. While either stream is stalled, the parser takes no further byte. The byte waiting in the input register then keeps the write-status busy bit set, and further host writes are dropped. A one-cycle `blk_done` pulse from the DMA engine marks the end of a block. The reported version comes from the `ver_sel` input.

Top module: `legacy_dsp_responder`

## Requirements
- R1: A write of data bit0=1 to the reset port (`hw_sel`=0), followed by a write with bit0=0, flushes the reply queue, the parser state, both streams and the interrupt flag. After this the queue holds exactly one byte, AAh. A command that was partly received is dropped, and the next byte is parsed as an opcode.
- R2: Bit 7 of read-status (`hr_sel`=3) is 1 exactly when a reply byte is queued. An `hr_en` read of read-data (`hr_sel`=2) returns the oldest queued byte and removes it. Replies leave the queue in the order they were generated.
- R3: Opcode E1h queues two bytes, major then minor, chosen by `ver_sel`: 0 gives 03h,01h; 1 gives 02h,01h; 2 gives 01h,05h; 3 gives 00h,00h.
- R4: Opcode 10h followed by one byte sends that byte on the sample stream. `smp_valid` stays high and `smp_data` stays stable until a cycle with `smp_ready` high.
- R5: Opcode 14h followed by a length low byte and then a high byte raises `dma_valid` with `dma_bytes` = length+1, a 17-bit value. The request holds until `dma_ready`.
- R6: A `blk_done` pulse sets `irq`. A read of read-data clears it. When both happen in the same cycle, `irq` ends up set.
- R7: Opcode 20h (direct record) queues the silence byte 80h. Opcode 24h (DMA record) takes two parameter bytes, raises no playback request and sets `irq`.
- R8: Bit 7 of write-status (`hr_sel`=1) is 1 in two cases: while a written byte has not yet been taken by the parser, and while the reset port holds 1. A command-port write (`hw_sel`=1) made while the bit is 1 is ignored.
- R9: Opcode E0h with one parameter queues the bitwise inverse of that parameter. Opcode E4h stores its parameter, and E8h queues the stored value.
- R10: Opcode D8h queues FFh when the speaker is on and 00h when it is off. D1h turns the speaker on and D3h turns it off. It is off after reset.
- R11: Any opcode outside the implemented set takes no parameter and queues nothing. The following byte is treated as a new opcode.
- R12: Opcode F2h sets `irq` without queueing a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 2 | Write port: 0 reset, 1 command/data |
| hw_data | input | 8 | Host write byte |
| hr_en | input | 1 | Host read strobe |
| hr_sel | input | 2 | Read port: 1 write-status, 2 read-data, 3 read-status |
| hr_data | output | 8 | Read byte for the selected port |
| ver_sel | input | 2 | Version select for opcode E1h |
| smp_valid | output | 1 | Direct sample valid |
| smp_ready | input | 1 | Direct sample accepted |
| smp_data | output | 8 | Direct sample byte |
| dma_valid | output | 1 | Playback request valid |
| dma_ready | input | 1 | Playback request accepted |
| dma_bytes | output | 17 | Bytes to transfer (length+1) |
| blk_done | input | 1 | Playback block finished pulse |
| irq | output | 1 | Interrupt flag |

## Verification
The parser is driven with several patterns. Zero-parameter queries show that replies come out in order. One- and two-parameter commands show that parameter bytes are taken in order and are never mistaken for opcodes. An unknown opcode followed directly by a query shows that the unknown opcode consumed nothing. A reset in the middle of a command shows that partial state is dropped. Both output streams are held stalled, and a write is made during the stall, which separates correct back-pressure from lost or duplicated bytes. The interrupt flag is set from each of its three sources, and a set and a clear land in the same cycle to check which one wins.

// File: rtl/dsp_resp_pkg.sv
package dsp_resp_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;

  localparam logic [1:0] WSEL_RESET = 2'd0;
  localparam logic [1:0] WSEL_CMD   = 2'd1;
  localparam logic [1:0] RSEL_WSTAT = 2'd1;
  localparam logic [1:0] RSEL_DATA  = 2'd2;
  localparam logic [1:0] RSEL_RSTAT = 2'd3;

  localparam logic [7:0] OP_DIRECT_OUT = 8'h10;
  localparam logic [7:0] OP_PLAY_SC    = 8'h14;
  localparam logic [7:0] OP_DIRECT_IN  = 8'h20;
  localparam logic [7:0] OP_REC_SC     = 8'h24;
  localparam logic [7:0] OP_TIMECONST  = 8'h40;
  localparam logic [7:0] OP_BLOCKSIZE  = 8'h48;
  localparam logic [7:0] OP_SPK_ON     = 8'hD1;
  localparam logic [7:0] OP_SPK_OFF    = 8'hD3;
  localparam logic [7:0] OP_SPK_QUERY  = 8'hD8;
  localparam logic [7:0] OP_INVERT     = 8'hE0;
  localparam logic [7:0] OP_VERSION    = 8'hE1;
  localparam logic [7:0] OP_TEST_WR    = 8'hE4;
  localparam logic [7:0] OP_TEST_RD    = 8'hE8;
  localparam logic [7:0] OP_FORCE_IRQ  = 8'hF2;

  localparam logic [7:0] RESET_ACK   = 8'hAA;
  localparam logic [7:0] SILENCE     = 8'h80;

  // number of parameter bytes following an opcode
  function automatic logic [1:0] param_count(input logic [7:0] op);
    case (op)
      OP_DIRECT_OUT, OP_TIMECONST, OP_INVERT, OP_TEST_WR: param_count = 2'd1;
      OP_PLAY_SC, OP_REC_SC, OP_BLOCKSIZE:                param_count = 2'd2;
      default:                                             param_count = 2'd0;
    endcase
  endfunction

  // {major, minor} reported for each version select code
  function automatic logic [15:0] version_word(input logic [1:0] sel);
    case (sel)
      2'd0:    version_word = 16'h0301;
      2'd1:    version_word = 16'h0201;
      2'd2:    version_word = 16'h0105;
      default: version_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/dsp_outq.sv
module dsp_outq #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    push_n,
  input  logic [W-1:0]  push_b0,
  input  logic [W-1:0]  push_b1,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          nonempty,
  output logic [CW-1:0] free
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr, base;
  logic [CW-1:0] count;
  logic          pop_eff;

  assign pop_eff  = pop && (count != '0);
  assign base     = flush ? '0 : wptr;
  assign nonempty = (count != '0);
  assign head     = mem[rptr];
  assign free     = CW'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[base] <= push_b0;
    if (push_n == 2'd2) mem[base + AW'(1)] <= push_b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (flush) begin
      rptr  <= '0;
      wptr  <= AW'(push_n);
      count <= CW'(push_n);
    end else begin
      rptr  <= rptr + AW'(pop_eff);
      wptr  <= wptr + AW'(push_n);
      count <= count + CW'(push_n) - CW'(pop_eff);
    end
  end

  // a push never exceeds the room the queue reports
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush) |-> (CW'(push_n) <= free));
endmodule

// File: rtl/dsp_cmd_parser.sv
module dsp_cmd_parser
  import dsp_resp_pkg::*;
#(
  parameter int FREE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_take,
  input  logic [1:0]        ver_sel,
  input  logic [FREE_W-1:0] free,
  output logic [1:0]        push_n,
  output logic [7:0]        push_b0,
  output logic [7:0]        push_b1,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [7:0]        smp_data,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [LEN_W:0]    dma_bytes,
  output logic              irq_set
);
  logic [1:0]  need;
  logic [7:0]  op_r, p_first, test_r;
  logic        spk_on;
  logic        exec;
  logic [7:0]  op_now;
  logic        smp_load, dma_load;
  logic [15:0] ver;

  assign in_take = in_valid && !smp_valid && !dma_valid && (free >= FREE_W'(2));
  assign op_now  = (need == 2'd0) ? in_data : op_r;
  assign exec    = in_take && (((need == 2'd0) && (param_count(in_data) == 2'd0)) ||
                               (need == 2'd1));
  assign ver     = version_word(ver_sel);

  always_comb begin
    push_n   = 2'd0;
    push_b0  = 8'h00;
    push_b1  = 8'h00;
    smp_load = 1'b0;
    dma_load = 1'b0;
    irq_set  = 1'b0;
    if (exec) begin
      case (op_now)
        OP_VERSION:   begin push_n = 2'd2; push_b0 = ver[15:8]; push_b1 = ver[7:0]; end
        OP_DIRECT_IN: begin push_n = 2'd1; push_b0 = SILENCE; end
        OP_INVERT:    begin push_n = 2'd1; push_b0 = ~in_data; end
        OP_TEST_RD:   begin push_n = 2'd1; push_b0 = test_r; end
        OP_SPK_QUERY: begin push_n = 2'd1; push_b0 = spk_on ? 8'hFF : 8'h00; end
        OP_REC_SC,
        OP_FORCE_IRQ: irq_set  = 1'b1;
        OP_DIRECT_OUT: smp_load = 1'b1;
        OP_PLAY_SC:   dma_load = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need      <= 2'd0;
      op_r      <= 8'h00;
      p_first   <= 8'h00;
      test_r    <= 8'h00;
      spk_on    <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= 8'h00;
      dma_valid <= 1'b0;
      dma_bytes <= '0;
    end else if (clr) begin
      need      <= 2'd0;
      spk_on    <= 1'b0;
      smp_valid <= 1'b0;
      dma_valid <= 1'b0;
    end else begin
      if (in_take) begin
        if (need == 2'd0) begin
          op_r <= in_data;
          need <= param_count(in_data);
        end else begin
          if (need == 2'd2) p_first <= in_data;
          need <= need - 2'd1;
        end
      end
      if (exec) begin
        case (op_now)
          OP_SPK_ON:  spk_on <= 1'b1;
          OP_SPK_OFF: spk_on <= 1'b0;
          OP_TEST_WR: test_r <= in_data;
          default: ;
        endcase
      end
      if (smp_load) begin
        smp_valid <= 1'b1;
        smp_data  <= in_data;
      end else if (smp_ready) begin
        smp_valid <= 1'b0;
      end
      if (dma_load) begin
        dma_valid <= 1'b1;
        dma_bytes <= {1'b0, in_data, p_first} + (LEN_W+1)'(1);
      end else if (dma_ready) begin
        dma_valid <= 1'b0;
      end
    end
  end

  // R4: a stalled sample stays offered and unchanged
  p_smp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !clr) |=> (smp_valid && $stable(smp_data)));
  // R5: a stalled playback request stays offered and unchanged
  p_dma_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready && !clr) |=> (dma_valid && $stable(dma_bytes)));
endmodule

// File: rtl/legacy_dsp_responder.sv
module legacy_dsp_responder
  import dsp_resp_pkg::*;
#(
  parameter int OQ_DEPTH = 4,
  localparam int FREE_W  = $clog2(OQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [1:0]       hw_sel,
  input  logic [7:0]       hw_data,
  input  logic             hr_en,
  input  logic [1:0]       hr_sel,
  output logic [7:0]       hr_data,
  input  logic [1:0]       ver_sel,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [7:0]       smp_data,
  output logic             dma_valid,
  input  logic             dma_ready,
  output logic [LEN_W:0]   dma_bytes,
  input  logic             blk_done,
  output logic             irq
);
  logic              rst_arm, soft_rst;
  logic              hold_v, busy, in_take, accept;
  logic [7:0]        hold_d;
  logic [1:0]        p_push_n, q_push_n;
  logic [7:0]        p_b0, p_b1, q_b0;
  logic              pop, q_nonempty, irq_set;
  logic [7:0]        q_head, last_rd;
  logic [FREE_W-1:0] q_free;

  assign soft_rst = hw_en && (hw_sel == WSEL_RESET) && !hw_data[0] && rst_arm;
  assign busy     = hold_v || rst_arm;
  assign accept   = hw_en && (hw_sel == WSEL_CMD) && !busy;
  assign pop      = hr_en && (hr_sel == RSEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_arm <= 1'b0;
      hold_v  <= 1'b0;
      hold_d  <= 8'h00;
      last_rd <= 8'h00;
      irq     <= 1'b0;
    end else begin
      if (hw_en && (hw_sel == WSEL_RESET)) rst_arm <= hw_data[0];
      if (soft_rst)      hold_v <= 1'b0;
      else if (accept) begin
        hold_v <= 1'b1;
        hold_d <= hw_data;
      end else if (in_take) hold_v <= 1'b0;
      if (pop && q_nonempty) last_rd <= q_head;
      if (soft_rst)                  irq <= 1'b0;
      else if (blk_done || irq_set)  irq <= 1'b1;
      else if (pop)                  irq <= 1'b0;
    end
  end

  dsp_cmd_parser #(.FREE_W(FREE_W)) parser_i (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .in_valid(hold_v), .in_data(hold_d), .in_take(in_take),
    .ver_sel(ver_sel), .free(q_free),
    .push_n(p_push_n), .push_b0(p_b0), .push_b1(p_b1),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_bytes(dma_bytes),
    .irq_set(irq_set)
  );

  assign q_push_n = soft_rst ? 2'd1 : p_push_n;
  assign q_b0     = soft_rst ? RESET_ACK : p_b0;

  dsp_outq #(.DEPTH(OQ_DEPTH), .W(BYTE_W)) outq_i (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push_n(q_push_n), .push_b0(q_b0), .push_b1(p_b1),
    .pop(pop), .head(q_head), .nonempty(q_nonempty), .free(q_free)
  );

  always_comb begin
    case (hr_sel)
      RSEL_WSTAT: hr_data = {busy, 7'h00};
      RSEL_DATA:  hr_data = q_nonempty ? q_head : last_rd;
      RSEL_RSTAT: hr_data = {q_nonempty, 7'h00};
      default:    hr_data = 8'hFF;
    endcase
  end

  // R1: completing the reset sequence leaves a reply waiting
  p_reset_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> q_nonempty);
  // R6: a finished block always raises the flag
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !soft_rst) |=> irq);
  // R8: a write made while busy never replaces the held byte
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && (hw_sel == WSEL_CMD) && hold_v && !in_take && !soft_rst) |=> $stable(hold_d));
endmodule

// File: tb/legacy_dsp_responder_tb_top.sv
`timescale 1ns/1ps
module legacy_dsp_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [1:0]  hw_sel = 2'd0;
  logic [7:0]  hw_data = 8'h00;
  logic        hr_en = 1'b0;
  logic [1:0]  hr_sel = 2'd0;
  logic [7:0]  hr_data;
  logic [1:0]  ver_sel = 2'd0;
  logic        smp_valid, smp_ready = 1'b1;
  logic [7:0]  smp_data;
  logic        dma_valid, dma_ready = 1'b1;
  logic [16:0] dma_bytes;
  logic        blk_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  legacy_dsp_responder dut_i (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .hr_en(hr_en), .hr_sel(hr_sel), .hr_data(hr_data), .ver_sel(ver_sel),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_bytes(dma_bytes),
    .blk_done(blk_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    hr_en = 1'b1; hr_sel = sel;
    #1 d = hr_data;
    @(negedge clk);
    hr_en = 1'b0;
  endtask

  // command write that first waits for the busy bit to clear
  task automatic cmd(input logic [7:0] d);
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      rd(2'd1, s);
      if (!s[7]) break;
    end
    wr(2'd1, d);
    idle(3);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] exp);
    logic [7:0] s, d;
    rd(2'd3, s);
    chk(s[7] == 1'b1, req, s, 8'h80);
    rd(2'd2, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic expect_empty(input string req);
    logic [7:0] s;
    rd(2'd3, s);
    chk(s[7] == 1'b0, req, s, 8'h00);
  endtask

  task automatic soft_reset();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    idle(2);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    expect_empty("R2 idle after power-on");
    chk(irq == 1'b0, "R6 irq after power-on", irq, 0);
    rd(2'd1, s);
    chk(s[7] == 1'b0, "R8 write-status idle", s, 0);
    wr(2'd0, 8'h01);
    rd(2'd1, s);
    chk(s[7] == 1'b1, "R8 busy while reset held", s, 8'h80);
    wr(2'd0, 8'h00);
    idle(2);
    expect_byte("R1 reset ack", 8'hAA);
    expect_empty("R2 queue empty after pop");
    // R1: reset in mid-command drops the partial command
    cmd(8'h10);
    soft_reset();
    expect_byte("R1 ack after mid-command reset", 8'hAA);
    cmd(8'hE1);
    expect_byte("R1 next byte parsed as opcode", 8'h03);
    expect_byte("R1 next byte parsed as opcode", 8'h01);
  endtask

  task automatic t_version();
    logic [15:0] exp;
    for (int v = 0; v < 4; v++) begin
      ver_sel = 2'(v);
      exp = (v == 0) ? 16'h0301 : (v == 1) ? 16'h0201 : (v == 2) ? 16'h0105 : 16'h0000;
      cmd(8'hE1);
      expect_byte("R3 version major", exp[15:8]);
      expect_byte("R3 version minor", exp[7:0]);
    end
    ver_sel = 2'd0;
  endtask

  task automatic t_direct();
    logic [7:0] s;
    smp_ready = 1'b0;
    cmd(8'h10);
    cmd(8'h5A);
    chk(smp_valid == 1'b1, "R4 sample offered", smp_valid, 1);
    chk(smp_data == 8'h5A, "R4 sample value", smp_data, 8'h5A);
    // a write during the stall is held; a second one is dropped
    wr(2'd1, 8'hE1);
    idle(3);
    rd(2'd1, s);
    chk(s[7] == 1'b1, "R8 busy while parser stalled", s, 8'h80);
    wr(2'd1, 8'hE8);
    idle(5);
    chk(smp_valid && smp_data == 8'h5A, "R4 sample held under stall", {smp_valid, smp_data}, 9'h15A);
    @(negedge clk); smp_ready = 1'b1;
    @(negedge clk); smp_ready = 1'b0;
    chk(smp_valid == 1'b0, "R4 sample released on ready", smp_valid, 0);
    idle(4);
    expect_byte("R8 held byte processed", 8'h03);
    expect_byte("R8 held byte processed", 8'h01);
    expect_empty("R8 write while busy ignored");
    smp_ready = 1'b1;
  endtask

  task automatic t_dma();
    dma_ready = 1'b0;
    cmd(8'h14); cmd(8'hFF); cmd(8'h03);
    chk(dma_valid == 1'b1, "R5 request offered", dma_valid, 1);
    chk(dma_bytes == 17'h00400, "R5 length+1", dma_bytes, 17'h400);
    idle(4);
    chk(dma_valid && dma_bytes == 17'h00400, "R5 request held", dma_bytes, 17'h400);
    @(negedge clk); dma_ready = 1'b1;
    @(negedge clk);
    chk(dma_valid == 1'b0, "R5 request released", dma_valid, 0);
    cmd(8'h14); cmd(8'hFF); cmd(8'hFF);
    chk(dma_bytes == 17'h10000, "R5 max length carries into bit 16", dma_bytes, 17'h10000);
    idle(2);
    cmd(8'h14); cmd(8'h00); cmd(8'h00);
    chk(dma_bytes == 17'h00001, "R5 zero length moves one byte", dma_bytes, 1);
    idle(2);
    chk(irq == 1'b0, "R6 no irq before block end", irq, 0);
    @(negedge clk); blk_done = 1'b1;
    @(negedge clk); blk_done = 1'b0;
    chk(irq == 1'b1, "R6 block end sets irq", irq, 1);
    begin logic [7:0] d; rd(2'd2, d); end
    chk(irq == 1'b0, "R6 read-data clears irq", irq, 0);
    @(negedge clk); blk_done = 1'b1; hr_en = 1'b1; hr_sel = 2'd2;
    @(negedge clk); blk_done = 1'b0; hr_en = 1'b0;
    chk(irq == 1'b1, "R6 set wins over clear", irq, 1);
    begin logic [7:0] d; rd(2'd2, d); end
  endtask

  task automatic t_record();
    cmd(8'h20);
    expect_byte("R7 direct record silence", 8'h80);
    cmd(8'h24); cmd(8'h10); cmd(8'h00);
    chk(dma_valid == 1'b0, "R7 record raises no playback", dma_valid, 0);
    chk(irq == 1'b1, "R7 record sets irq", irq, 1);
    expect_empty("R7 record queues nothing");
    begin logic [7:0] d; rd(2'd2, d); end
    chk(irq == 1'b0, "R7 irq cleared by read", irq, 0);
  endtask

  task automatic t_test();
    cmd(8'hE0); cmd(8'h3C);
    expect_byte("R9 invert", 8'hC3);
    cmd(8'hE4); cmd(8'h99);
    expect_empty("R9 test write silent");
    cmd(8'hE8);
    expect_byte("R9 test read", 8'h99);
  endtask

  task automatic t_speaker();
    cmd(8'hD8); expect_byte("R10 speaker off", 8'h00);
    cmd(8'hD1); cmd(8'hD8); expect_byte("R10 speaker on", 8'hFF);
    cmd(8'hD3); cmd(8'hD8); expect_byte("R10 speaker off again", 8'h00);
  endtask

  task automatic t_unknown();
    cmd(8'h55);
    expect_empty("R11 unknown opcode silent");
    cmd(8'h55); cmd(8'hE1);
    expect_byte("R11 no parameter taken", 8'h03);
    expect_byte("R11 no parameter taken", 8'h01);
  endtask

  task automatic t_force();
    chk(irq == 1'b0, "R12 irq clear before", irq, 0);
    cmd(8'hF2);
    chk(irq == 1'b1, "R12 forced irq", irq, 1);
    expect_empty("R12 nothing queued");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_version();
    t_direct();
    t_dma();
    t_record();
    t_test();
    t_speaker();
    t_unknown();
    t_force();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule